// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sends one command at a time to a card-side command port and captures the card's reply into four 32-bit response words. Software-side logic writes a 32-bit argument register and a 32-bit command word. Writing a command word with its enable bit set starts a command. The block decodes the command word and sends the 6-bit command index and the argument to the card as one request beat on a valid/ready handshake. It then waits for the card's answer.

The card answers with a byte stream. Each data beat carries one byte, and a final end beat closes the answer and can flag a card error. The block counts and stores the bytes. It accepts the answer only when its length matches what the command asked for. It packs the bytes most-significant byte first into the response words. It signals the outcome with one of three single-cycle event pulses: sent, response-end or timeout. When a command finishes, the enable bit in the stored command word clears by itself.

Top module: `card_cmd_capture`

## Requirements
- R1: A command is launched by a command write with bit 10 set while idle. The request beat carries bits 5:0 of the command word as the index and the argument register's value at launch time. Index and argument stay stable while req_valid is high and req_ready is low.
- R2: A command write with bit 10 clear only stores the word, with no request and no event. After any command finishes, cmd_word reads back the written word with bit 10 cleared.
- R3: An enabled command word with bit 8 (interrupt wait) or bit 9 (pending mode) set is refused. No request is issued. One cycle later evt_timeout pulses and bit 10 reads back clear.
- R4: busy is high from the cycle after launch until the cycle after the end beat. Command writes while busy have no effect on cmd_word or on the running command.
- R5: With bit 6 clear (no response wanted), an end beat without error gives evt_sent, and data bytes are ignored. An end beat with error gives evt_timeout. The response words are not changed in either case.
- R6: With bit 6 set and bit 7 clear, an answer of exactly 4 bytes loads word 0 with the first byte in bits 31:24 and the fourth byte in bits 7:0. It zeros words 1 to 3 and pulses evt_resp_end.
- R7: A 16-byte answer loads words 0 to 3 in order, each packed with its first byte most significant. Bit 0 of word 3 is forced to 0, and evt_resp_end pulses.
- R8: A 16-byte answer is accepted even when bit 7 (long) is clear.
- R9: With a response wanted, the answer fails if the card flags an error, if the length is neither 4 nor 16, or if 4 bytes arrive for a long request. A failed answer gives evt_timeout and leaves all response words unchanged.
- R10: The three event pulses last one cycle each, at most one is high at a time, and they appear in the cycle after the completing beat.
- R11: Response beats that arrive while no command is waiting for an answer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write value |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write value |
| cmd_word | output | 32 | Stored command word (enable self-clears) |
| busy | output | 1 | Command in flight |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Card accepts request beat |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_valid | input | 1 | Response beat valid |
| rsp_data | input | 8 | Response byte (data beats) |
| rsp_end | input | 1 | Beat closes the answer |
| rsp_err | input | 1 | Card error, qualified by rsp_end |
| resp_w0 | output | 32 | Response word 0 |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 |
| evt_sent | output | 1 | Pulse: command sent, no response wanted |
| evt_resp_end | output | 1 | Pulse: valid response captured |
| evt_timeout | output | 1 | Pulse: command refused or failed |

## Verification
A wrong byte counter or a wrong slot select shows up at the end beat of the same command. It appears as the wrong event pulse, or as response words with shifted or reversed bytes, one cycle after the closing beat. A state machine stuck in the wrong state shows at once on busy and req_valid, and on the next command as a missing request or a refused launch. Words that load on a failed answer, or that fail to clear bit 0 of word 3, differ from the bench's own byte packing at the first check after completion.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 6;
  localparam int B_WANT   = 6;
  localparam int B_LONG   = 7;
  localparam int B_WAITI  = 8;
  localparam int B_PEND   = 9;
  localparam int B_EN     = 10;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2} ccr_state_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             want;
    logic             lng;
    logic             waiti;
    logic             pend;
    logic             en;
  } ccr_fields_t;

  function automatic ccr_fields_t ccr_decode(input logic [WORD_W-1:0] w);
    ccr_fields_t f;
    f.idx   = w[IDX_W-1:0];
    f.want  = w[B_WANT];
    f.lng   = w[B_LONG];
    f.waiti = w[B_WAITI];
    f.pend  = w[B_PEND];
    f.en    = w[B_EN];
    return f;
  endfunction

  // big-endian packing: earliest byte lands in the top lane
  function automatic logic [WORD_W-1:0] ccr_pack(input logic [7:0] b0, input logic [7:0] b1,
                                                 input logic [7:0] b2, input logic [7:0] b3);
    return {b0, b1, b2, b3};
  endfunction

  function automatic logic ccr_len_ok(input int unsigned cnt, input logic lng,
                                      input int unsigned short_n, input int unsigned long_n);
    return (cnt == long_n) || ((cnt == short_n) && !lng);
  endfunction
endpackage

// File: rtl/ccr_cmd_decode.sv
module ccr_cmd_decode
  import ccr_pkg::*;
(
  input  logic [WORD_W-1:0] wdata,
  input  logic              we,
  input  logic              busy,
  output ccr_fields_t       fields,
  output logic              launch,
  output logic              refuse,
  output logic              store
);
  always_comb begin
    fields = ccr_decode(wdata);
    store  = we && !busy;
    launch = store && fields.en && !fields.waiti && !fields.pend;
    refuse = store && fields.en && (fields.waiti || fields.pend);
  end
endmodule

// File: rtl/ccr_byte_collect.sv
module ccr_byte_collect #(
  parameter int LONG_BYTES = 16,
  localparam int CNT_W = $clog2(LONG_BYTES + 2)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    take,
  input  logic [7:0]              data,
  output logic [CNT_W-1:0]        count,
  output logic [LONG_BYTES*8-1:0] bytes
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LONG_BYTES + 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else if (take && count != SAT) begin
      count <= count + 1'b1;
    end
  end

  for (genvar i = 0; i < LONG_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bytes[i*8 +: 8] <= '0;
      end else if (take && count == CNT_W'(i)) begin
        bytes[i*8 +: 8] <= data;
      end
    end
  end
endmodule

// File: rtl/ccr_resp_regs.sv
module ccr_resp_regs
  import ccr_pkg::*;
#(
  parameter int NWORDS = 4,
  localparam int NB = NWORDS * 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_short,
  input  logic                     load_long,
  input  logic [NB*8-1:0]          bytes,
  output logic [NWORDS*WORD_W-1:0] words
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] packed_w;
    always_comb begin
      packed_w = ccr_pack(bytes[(w*4+0)*8 +: 8], bytes[(w*4+1)*8 +: 8],
                          bytes[(w*4+2)*8 +: 8], bytes[(w*4+3)*8 +: 8]);
      if (w == NWORDS - 1) packed_w[0] = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[w*WORD_W +: WORD_W] <= '0;
      end else if (load_long) begin
        words[w*WORD_W +: WORD_W] <= packed_w;
      end else if (load_short) begin
        if (w == 0) words[w*WORD_W +: WORD_W] <= packed_w;
        else        words[w*WORD_W +: WORD_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/card_cmd_capture.sv
module card_cmd_capture
  import ccr_pkg::*;
#(
  parameter int SHORT_BYTES = 4,
  parameter int LONG_BYTES  = 16,
  localparam int NWORDS = LONG_BYTES / 4,
  localparam int CNT_W  = $clog2(LONG_BYTES + 2)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arg_we,
  input  logic [31:0] arg_wdata,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_word,
  output logic        busy,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [5:0]  req_index,
  output logic [31:0] req_arg,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_data,
  input  logic        rsp_end,
  input  logic        rsp_err,
  output logic [31:0] resp_w0,
  output logic [31:0] resp_w1,
  output logic [31:0] resp_w2,
  output logic [31:0] resp_w3,
  output logic        evt_sent,
  output logic        evt_resp_end,
  output logic        evt_timeout
);
  ccr_state_e       st;
  ccr_fields_t      dec;
  logic             launch, refuse, store;
  logic [31:0]      arg_q;
  logic             want_q, long_q;
  logic [CNT_W-1:0] byte_cnt;
  logic [LONG_BYTES*8-1:0] byte_buf;
  logic [NWORDS*WORD_W-1:0] words;

  // named internal events
  logic fin_beat, take_byte, len_ok, ans_ok, ld_short, ld_long;

  assign busy      = (st != ST_IDLE);
  assign req_valid = (st == ST_ISSUE);
  assign fin_beat  = (st == ST_WAIT) && rsp_valid && rsp_end;
  assign take_byte = (st == ST_WAIT) && rsp_valid && !rsp_end && want_q;
  assign len_ok    = ccr_len_ok(32'(byte_cnt), long_q, SHORT_BYTES, LONG_BYTES);
  assign ans_ok    = want_q && len_ok && !rsp_err;
  assign ld_long   = fin_beat && ans_ok && (byte_cnt == CNT_W'(LONG_BYTES));
  assign ld_short  = fin_beat && ans_ok && (byte_cnt == CNT_W'(SHORT_BYTES));

  ccr_cmd_decode u_dec (
    .wdata (cmd_wdata), .we (cmd_we), .busy (busy),
    .fields(dec), .launch(launch), .refuse(refuse), .store(store)
  );

  ccr_byte_collect #(.LONG_BYTES(LONG_BYTES)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(launch), .take(take_byte),
    .data(rsp_data), .count(byte_cnt), .bytes(byte_buf)
  );

  ccr_resp_regs #(.NWORDS(NWORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_short(ld_short), .load_long(ld_long),
    .bytes(byte_buf), .words(words)
  );

  assign resp_w0 = words[0*WORD_W +: WORD_W];
  assign resp_w1 = words[1*WORD_W +: WORD_W];
  assign resp_w2 = words[2*WORD_W +: WORD_W];
  assign resp_w3 = words[3*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) arg_q <= '0;
    else if (arg_we) arg_q <= arg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cmd_word  <= '0;
      req_index <= '0;
      req_arg   <= '0;
      want_q    <= 1'b0;
      long_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (launch) st <= ST_ISSUE;
        ST_ISSUE: if (req_ready) st <= ST_WAIT;
        ST_WAIT: if (fin_beat) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (store) begin
        cmd_word <= cmd_wdata;
        if (refuse) cmd_word[B_EN] <= 1'b0;
      end else if (fin_beat) begin
        cmd_word[B_EN] <= 1'b0;
      end
      if (launch) begin
        req_index <= dec.idx;
        req_arg   <= arg_q;
        want_q    <= dec.want;
        long_q    <= dec.lng;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_sent     <= 1'b0;
      evt_resp_end <= 1'b0;
      evt_timeout  <= 1'b0;
    end else begin
      evt_sent     <= fin_beat && !want_q && !rsp_err;
      evt_resp_end <= fin_beat && ans_ok;
      evt_timeout  <= refuse || (fin_beat && (want_q ? !ans_ok : rsp_err));
    end
  end
endmodule

// File: rtl/card_cmd_capture_chk.sv
module card_cmd_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_word,
  input logic        busy,
  input logic        req_valid,
  input logic        req_ready,
  input logic [5:0]  req_index,
  input logic [31:0] req_arg,
  input logic [31:0] resp_w0,
  input logic [31:0] resp_w1,
  input logic [31:0] resp_w2,
  input logic [31:0] resp_w3,
  input logic        evt_sent,
  input logic        evt_resp_end,
  input logic        evt_timeout,
  input logic        fin_beat
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_index) && $stable(req_arg)); // R1
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy); // R4
  AST_EN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sent || evt_resp_end || evt_timeout) |-> !cmd_word[10]); // R2
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_we && !fin_beat |=> $stable(cmd_word)); // R4
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_sent, evt_resp_end, evt_timeout})); // R10
  AST_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sent || evt_resp_end || evt_timeout) |=> !(evt_sent || evt_resp_end || evt_timeout)); // R10
  AST_W3_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resp_end |-> !resp_w3[0]); // R7
  AST_WORDS_ONLY_ON_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_resp_end |-> $stable({resp_w0, resp_w1, resp_w2, resp_w3})); // R9
endmodule

bind card_cmd_capture card_cmd_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word), .busy(busy),
  .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index), .req_arg(req_arg),
  .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3),
  .evt_sent(evt_sent), .evt_resp_end(evt_resp_end), .evt_timeout(evt_timeout),
  .fin_beat(fin_beat)
);

// File: tb/card_cmd_capture_bench.sv
module card_cmd_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arg_we = 1'b0, cmd_we = 1'b0;
  logic [31:0] arg_wdata = '0, cmd_wdata = '0;
  logic [31:0] cmd_word;
  logic        busy, req_valid;
  logic        req_ready = 1'b0;
  logic [5:0]  req_index;
  logic [31:0] req_arg;
  logic        rsp_valid = 1'b0, rsp_end = 1'b0, rsp_err = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;
  logic        evt_sent, evt_resp_end, evt_timeout;

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [31:0]  exp_arg = '0;
  logic [127:0] exp_words = '0;
  logic [7:0]   tb_bytes [20];

  card_cmd_capture u_card_cmd_capture (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] be_word(input int base);
    return {tb_bytes[base], tb_bytes[base+1], tb_bytes[base+2], tb_bytes[base+3]};
  endfunction

  function automatic logic [2:0] evts();
    return {evt_sent, evt_resp_end, evt_timeout};
  endfunction

  task automatic write_arg(input logic [31:0] v);
    @(negedge clk); arg_we = 1'b1; arg_wdata = v;
    @(negedge clk); arg_we = 1'b0;
    exp_arg = v;
  endtask

  task automatic check_words(input string req);
    logic [127:0] act;
    act = {resp_w3, resp_w2, resp_w1, resp_w0};
    chk(act == exp_words, req, act, exp_words);
  endtask

  // Full command: write, handshake, bytes, end beat, then check at ports.
  task automatic do_cmd(input logic [31:0] cw, input int nb, input logic err, input int rdly);
    logic en, mode, want, lng, ok;
    logic [2:0] exp_ev;
    en = cw[10]; mode = cw[8] | cw[9]; want = cw[6]; lng = cw[7];
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = cw;
    @(negedge clk); cmd_we = 1'b0;
    if (!en) begin
      chk(cmd_word == cw && !busy && evts() == 3'b000, "R2 store-only",
          {95'd0, busy, cmd_word}, {96'd0, cw});
      return;
    end
    if (mode) begin
      chk(evts() == 3'b001 && !busy && !req_valid, "R3 refused",
          {evts(), busy, req_valid}, {3'b001, 2'b00});
      chk(cmd_word == (cw & ~32'h400), "R3 enable clear", cmd_word, cw & ~32'h400);
      check_words("R3 words kept");
      return;
    end
    chk(busy && req_valid && req_index == cw[5:0] && req_arg == exp_arg, "R1 request",
        {busy, req_valid, req_index, req_arg}, {2'b11, cw[5:0], exp_arg});
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      chk(req_valid && req_index == cw[5:0] && req_arg == exp_arg, "R1 hold",
          {req_valid, req_arg}, {1'b1, exp_arg});
    end
    req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    chk(busy && !req_valid, "R4 busy after handshake", {busy, req_valid}, 2'b10);
    for (int i = 0; i < nb; i++) begin
      rsp_valid = 1'b1; rsp_data = tb_bytes[i];
      @(negedge clk);
    end
    rsp_valid = 1'b1; rsp_end = 1'b1; rsp_err = err;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_end = 1'b0; rsp_err = 1'b0;
    if (!want) begin
      exp_ev = err ? 3'b001 : 3'b100;
      chk(evts() == exp_ev, "R5 no-response event", evts(), exp_ev);
      check_words("R5 words kept");
    end else begin
      ok = !err && (nb == 16 || (nb == 4 && !lng));
      exp_ev = ok ? 3'b010 : 3'b001;
      if (ok && nb == 4) exp_words = {96'd0, be_word(0)};
      if (ok && nb == 16)
        exp_words = {be_word(12) & 32'hFFFF_FFFE, be_word(8), be_word(4), be_word(0)};
      chk(evts() == exp_ev, ok ? (nb == 4 ? "R6 short event" : "R7 long event") : "R9 timeout",
          evts(), exp_ev);
      check_words(ok ? (nb == 4 ? "R6 short words" : (lng ? "R7 long words" : "R8 long on short"))
                     : "R9 words kept");
    end
    chk(!busy && cmd_word == (cw & ~32'h400), "R2 self-clear", {busy, cmd_word}, {1'b0, cw & ~32'h400});
    @(negedge clk);
    chk(evts() == 3'b000, "R10 one-cycle pulse", evts(), 3'b000);
  endtask

  task automatic fill_bytes();
    for (int i = 0; i < 20; i++) tb_bytes[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid && cmd_word == 0 && evts() == 0, "R2 reset state",
        {busy, req_valid, evts(), cmd_word}, 0);
    check_words("R9 reset words");

    // directed corner cases
    write_arg(32'hCAFE_0001);
    for (int i = 0; i < 16; i++) tb_bytes[i] = 8'(8'h10 + i);
    tb_bytes[15] = 8'hFF;
    do_cmd(32'h0000_04C2, 16, 1'b0, 2);     // R7 long, bit0 of word 3 cleared
    do_cmd(32'h0000_0451, 4, 1'b0, 0);      // R6 short
    do_cmd(32'h0000_04C5, 4, 1'b0, 1);      // R9 4 bytes for long
    do_cmd(32'h0000_0447, 5, 1'b0, 0);      // R9 bad length
    do_cmd(32'h0000_0448, 4, 1'b1, 0);      // R9 card error
    do_cmd(32'h0000_0409, 3, 1'b0, 0);      // R5 no response, bytes ignored
    do_cmd(32'h0000_040A, 0, 1'b1, 0);      // R5 error
    do_cmd(32'h0000_0446, 16, 1'b0, 0);     // R8 16 bytes, short requested
    do_cmd(32'h0000_0503, 0, 1'b0, 0);      // R3 interrupt wait
    do_cmd(32'h0000_0603, 0, 1'b0, 0);      // R3 pending
    do_cmd(32'h0000_0043, 0, 1'b0, 0);      // R2 store only

    // R4: command write during a running command is ignored
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 32'h0000_0411;
    @(negedge clk); cmd_wdata = 32'h0000_04FF;
    @(negedge clk); cmd_we = 1'b0;
    chk(cmd_word == 32'h0000_0411 && busy && req_index == 6'h11, "R4 write while busy",
        {req_index, cmd_word}, {6'h11, 32'h0000_0411});
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_end = 1'b1; @(negedge clk); rsp_valid = 1'b0; rsp_end = 1'b0;
    chk(evts() == 3'b100 && cmd_word == 32'h0000_0011, "R4 first command finishes",
        {evts(), cmd_word}, {3'b100, 32'h0000_0011});

    // R11: beats while idle are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rsp_valid = 1'b1; rsp_data = 8'hA5;
    end
    rsp_end = 1'b1; @(negedge clk); rsp_valid = 1'b0; rsp_end = 1'b0;
    chk(evts() == 3'b000 && !busy, "R11 idle beats no event", {evts(), busy}, 0);
    check_words("R11 idle beats words kept");

    // constrained random commands
    for (int k = 0; k < 60; k++) begin
      int sel, nb;
      logic [31:0] cw;
      logic err;
      fill_bytes();
      if ($urandom % 3 == 0) write_arg($urandom);
      cw = {21'($urandom), 1'b1, 4'b0000, 6'($urandom)};
      sel = $urandom % 8;
      err = 1'b0;
      case (sel)
        0: begin cw[6] = 1'b0; err = ($urandom % 4 == 0); end
        1, 2: cw[6] = 1'b1;
        3, 4: begin cw[6] = 1'b1; cw[7] = 1'b1; end
        5: begin cw[6] = 1'b1; cw[8 + ($urandom % 2)] = 1'b1; end
        default: begin cw[6] = 1'b1; err = ($urandom % 2 == 0); cw[7] = 1'($urandom); end
      endcase
      case ($urandom % 6)
        0, 1: nb = 4;
        2, 3: nb = 16;
        4: nb = 3 + 2 * ($urandom % 2);
        default: nb = 15 + 2 * ($urandom % 2);
      endcase
      do_cmd(cw, nb, err, $urandom % 4);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule